// File: doc/BRIEF.md
# Ring-Descriptor Receive DMA

This block moves frames arriving on a byte-wide MAC receive stream into memory buffers. The buffers are described by a circular chain of descriptors. Each descriptor is three 32-bit words. The word at offset 0 holds the buffer's base address. The word at offset 4 holds a control word with an ownership flag in bit 31 and the buffer capacity in bits 11:0. The word at offset 8 points to the next descriptor. The host gives a descriptor to the engine by setting the ownership ("empty") flag. The engine gives it back by clearing that flag and writing the stored length into bits 11:0.

The host loads the address of the first descriptor and then sets the run bit. When the first byte of a frame arrives, the engine reads the current descriptor and holds off the stream until the read is done. It packs bytes big-endian into 32-bit words and writes them with byte enables. When the frame ends it writes the descriptor back and moves on to the next one. The stored length counts every byte of the stream, including the trailing 4-byte frame check sequence.

If the engine meets a descriptor the host still owns, or if a memory access fails, it discards the rest of the frame, raises a sticky status flag and clears its own run bit. The host restarts it by writing the descriptor pointer and then setting the run bit again. A pending counter tracks descriptors that have completed but that the host has not yet acknowledged.

Top module: `rxdma_top`

## Requirements
- R1: After reset the run bit, the descriptor pointer and all status bits read 0, `rx_ready` is 0 and `mem_req` is 0.
- R2: While the run bit is 0 and no frame is in progress, an offered byte is not accepted (`rx_ready` stays 0) and no memory write is issued.
- R3: For each frame the engine reads the descriptor's control word (pointer+4), buffer address (pointer+0) and next pointer (pointer+8). After a good writeback the pointer register takes the next-pointer value, so the ring wraps wherever the chain points.
- R4: Frame byte n is written to buffer base + (n rounded down to a multiple of 4), in bits [31-8k:24-8k] with byte enable bit 3-k, where k = n mod 4. A partial last word enables only its stored lanes.
- R5: On a good frame end, the control word is written as bit 31 = 0, bits 11:0 = byte count including the 4 FCS bytes, and all other bits 0.
- R6: If a frame is longer than the capacity, only the first capacity bytes are stored, the rest are accepted and discarded, and the recorded length equals the capacity.
- R7: If the fetched control word has bit 31 = 0, the frame is accepted and discarded. Status bit 2 (overflow) is set, the run bit is cleared, no memory write occurs and the pointer is unchanged.
- R8: A frame with `rx_err` set on any byte gets no descriptor writeback and no status change. The same descriptor serves the next frame.
- R9: `mem_err` on any access sets status bit 3 (bus error) and clears the run bit. The remainder of the frame is accepted and discarded, and the descriptor is not written back.
- R10: Status bit 0 reads 1 while the count of completed, unacknowledged descriptors is non-zero. Writing 1 to bit 0 acknowledges one. Writing 1 to bit 2 or bit 3 clears that bit.
- R11: After a stop, writing a new pointer and then setting the run bit makes the next frame use the new descriptor.
- R12: Registers are addressed by `reg_addr`: 0 = control (bit 0 run), 1 = descriptor pointer, 2 = status. Reads return the current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rx_valid | input | 1 | Stream byte present |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Byte carries a receive error |
| rx_ready | output | 1 | Engine accepts the byte this cycle |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables, bit 3 = bits 31:24 |
| mem_ack | input | 1 | Access completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Access failed, valid with `mem_ack` |

## Verification
The hardest case to reach is a bus error partway through a frame, after the descriptor reads have succeeded. The bench's memory model has a single faulting address. It places that address on the first buffer word of one descriptor, so the fault lands on a data write while stream bytes are still pending. It then checks that the rest of the frame drains and the control word is left alone. Reaching the owned-descriptor stop takes a similar step: the bench hands back a descriptor with its flag clear, so the engine runs into it on the next frame.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int SIZE_W    = 12;
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_W    = $clog2(LANES);
  localparam int EMPTY_BIT = 31;
  localparam int ST_PKT    = 0;
  localparam int ST_OVF    = 2;
  localparam int ST_BERR   = 3;

  typedef enum logic [1:0] {DF_BUF = 2'd0, DF_CTRL = 2'd1, DF_NEXT = 2'd2} desc_field_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_CTRL, S_RD_BUF, S_RD_NEXT, S_RECV, S_WR_DATA, S_WR_DESC, S_DRAIN
  } eng_state_e;

  function automatic logic [ADDR_W-1:0] desc_addr(logic [ADDR_W-1:0] base, desc_field_e f);
    return base + {{(ADDR_W-4){1'b0}}, f, 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(logic [ADDR_W-1:0] base, logic [SIZE_W-1:0] idx);
    logic [ADDR_W-1:0] off;
    off = {{(ADDR_W-SIZE_W){1'b0}}, idx};
    return base + (off & ~ADDR_W'(LANES-1));
  endfunction

  function automatic logic [LANE_W-1:0] lane_of(logic [SIZE_W-1:0] idx);
    return idx[LANE_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] done_word(logic [SIZE_W-1:0] len);
    return {{(DATA_W-SIZE_W){1'b0}}, len};
  endfunction
endpackage

// File: rtl/rxd_csr.sv
module rxd_csr
  import rxd_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_pkt_done,
  input  logic              ev_overflow,
  input  logic              ev_bus_err,
  input  logic [ADDR_W-1:0] next_ptr,
  output logic              run_en,
  output logic [ADDR_W-1:0] desc_ptr,
  output logic              st_pkt,
  output logic              st_ovf,
  output logic              st_berr
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] pend;
  logic wr_ctrl, wr_ptr, wr_stat, ack_pkt;

  assign wr_ctrl = reg_wr && (reg_addr == 2'd0);
  assign wr_ptr  = reg_wr && (reg_addr == 2'd1);
  assign wr_stat = reg_wr && (reg_addr == 2'd2);
  assign ack_pkt = wr_stat && reg_wdata[ST_PKT] && (pend != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      desc_ptr <= '0;
      pend     <= '0;
      st_ovf   <= 1'b0;
      st_berr  <= 1'b0;
    end else begin
      if (ev_overflow || ev_bus_err) run_en <= 1'b0;
      else if (wr_ctrl)              run_en <= reg_wdata[0];

      if (wr_ptr)           desc_ptr <= reg_wdata;
      else if (ev_pkt_done) desc_ptr <= next_ptr;

      if (ev_pkt_done && !ack_pkt && pend != PEND_MAX) pend <= pend + 1'b1;
      else if (ack_pkt && !ev_pkt_done)                pend <= pend - 1'b1;

      if (ev_overflow)                     st_ovf <= 1'b1;
      else if (wr_stat && reg_wdata[ST_OVF]) st_ovf <= 1'b0;

      if (ev_bus_err)                        st_berr <= 1'b1;
      else if (wr_stat && reg_wdata[ST_BERR]) st_berr <= 1'b0;
    end
  end

  assign st_pkt = (pend != '0);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[0] = run_en;
      2'd1: reg_rdata = desc_ptr;
      2'd2: begin
        reg_rdata[ST_PKT]  = st_pkt;
        reg_rdata[ST_OVF]  = st_ovf;
        reg_rdata[ST_BERR] = st_berr;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ld,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        din,
  output logic [DATA_W-1:0] word,
  output logic [LANES-1:0]  be
);
  logic [7:0] lane_q [LANES];
  logic       lane_v [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[g] <= '0;
        lane_v[g] <= 1'b0;
      end else if (clr) begin
        lane_q[g] <= '0;
        lane_v[g] <= 1'b0;
      end else if (ld && lane == LANE_W'(g)) begin
        lane_q[g] <= din;
        lane_v[g] <= 1'b1;
      end
    end
    assign word[(LANES-1-g)*8 +: 8] = lane_q[g];
    assign be[LANES-1-g]            = lane_v[g];
  end
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [ADDR_W-1:0] desc_ptr,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err,
  output logic              rx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              ev_pkt_done,
  output logic              ev_overflow,
  output logic              ev_bus_err,
  output logic [ADDR_W-1:0] next_ptr,
  output logic [SIZE_W-1:0] cur_cap
);
  eng_state_e        state;
  logic [ADDR_W-1:0] cur_desc, buf_base, nxt, wr_addr;
  logic [SIZE_W-1:0] cap, cnt;
  logic              last_seen, err_seen;
  logic              store, flush, pk_ld, pk_clr;
  logic [DATA_W-1:0] pk_word;
  logic [LANES-1:0]  pk_be;

  assign store = (cnt < cap);
  assign flush = (lane_of(cnt) == LANE_W'(LANES-1)) || rx_last || (SIZE_W'(cnt + 1'b1) == cap);
  assign rx_ready = (state == S_RECV) || (state == S_DRAIN);
  assign pk_ld  = (state == S_RECV) && rx_valid && store;
  assign pk_clr = (state == S_IDLE) || ((state == S_WR_DATA) && mem_ack);

  rxd_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .ld(pk_ld),
    .lane(lane_of(cnt)), .din(rx_data), .word(pk_word), .be(pk_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_desc  <= '0;
      buf_base  <= '0;
      nxt       <= '0;
      wr_addr   <= '0;
      cap       <= '0;
      cnt       <= '0;
      last_seen <= 1'b0;
      err_seen  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (run_en && rx_valid) begin
          state     <= S_RD_CTRL;
          cur_desc  <= desc_ptr;
          cnt       <= '0;
          last_seen <= 1'b0;
          err_seen  <= 1'b0;
        end
        S_RD_CTRL: if (mem_ack) begin
          if (mem_err || !mem_rdata[EMPTY_BIT]) state <= S_DRAIN;
          else begin
            cap   <= mem_rdata[SIZE_W-1:0];
            state <= S_RD_BUF;
          end
        end
        S_RD_BUF: if (mem_ack) begin
          if (mem_err) state <= S_DRAIN;
          else begin
            buf_base <= mem_rdata;
            state    <= S_RD_NEXT;
          end
        end
        S_RD_NEXT: if (mem_ack) begin
          if (mem_err) state <= S_DRAIN;
          else begin
            nxt   <= mem_rdata;
            state <= S_RECV;
          end
        end
        S_RECV: if (rx_valid) begin
          if (rx_err) err_seen <= 1'b1;
          if (store) begin
            cnt     <= cnt + 1'b1;
            wr_addr <= word_addr(buf_base, cnt);
            if (flush) begin
              last_seen <= rx_last;
              state     <= S_WR_DATA;
            end
          end else if (rx_last) begin
            state <= (err_seen || rx_err) ? S_IDLE : S_WR_DESC;
          end
        end
        S_WR_DATA: if (mem_ack) begin
          if (mem_err)        state <= last_seen ? S_IDLE : S_DRAIN;
          else if (last_seen) state <= err_seen ? S_IDLE : S_WR_DESC;
          else                state <= S_RECV;
        end
        S_WR_DESC: if (mem_ack) state <= S_IDLE;
        S_DRAIN:   if (rx_valid && rx_last) state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '1;
    case (state)
      S_RD_CTRL: begin mem_req = 1'b1; mem_addr = desc_addr(cur_desc, DF_CTRL); end
      S_RD_BUF:  begin mem_req = 1'b1; mem_addr = desc_addr(cur_desc, DF_BUF);  end
      S_RD_NEXT: begin mem_req = 1'b1; mem_addr = desc_addr(cur_desc, DF_NEXT); end
      S_WR_DATA: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = wr_addr;
        mem_wdata = pk_word; mem_be = pk_be;
      end
      S_WR_DESC: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_addr(cur_desc, DF_CTRL);
        mem_wdata = done_word(cnt);
      end
      default: ;
    endcase
  end

  assign ev_bus_err  = mem_req && mem_ack && mem_err;
  assign ev_overflow = (state == S_RD_CTRL) && mem_ack && !mem_err && !mem_rdata[EMPTY_BIT];
  assign ev_pkt_done = (state == S_WR_DESC) && mem_ack && !mem_err;
  assign next_ptr    = nxt;
  assign cur_cap     = cap;
endmodule

// File: rtl/rxdma_top.sv
module rxdma_top
  import rxd_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        rx_err,
  output logic        rx_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err
);
  logic              run_en, st_pkt, st_ovf, st_berr;
  logic              ev_pkt_done, ev_overflow, ev_bus_err;
  logic [ADDR_W-1:0] desc_ptr, next_ptr;
  logic [SIZE_W-1:0] cur_cap;

  rxd_csr #(.PEND_W(PEND_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_pkt_done(ev_pkt_done), .ev_overflow(ev_overflow), .ev_bus_err(ev_bus_err),
    .next_ptr(next_ptr), .run_en(run_en), .desc_ptr(desc_ptr),
    .st_pkt(st_pkt), .st_ovf(st_ovf), .st_berr(st_berr)
  );

  rxd_engine u_eng (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .desc_ptr(desc_ptr),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
    .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .ev_pkt_done(ev_pkt_done), .ev_overflow(ev_overflow),
    .ev_bus_err(ev_bus_err), .next_ptr(next_ptr), .cur_cap(cur_cap)
  );
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [3:0]  mem_be,
  input logic        rx_ready,
  input logic        run_en,
  input logic        st_pkt,
  input logic        st_ovf,
  input logic        st_berr,
  input logic        ev_pkt_done,
  input logic        ev_overflow,
  input logic        ev_bus_err,
  input logic [11:0] cur_cap
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3

  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != 4'h0); // R4

  AST_NO_BYTE_DURING_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rx_ready); // R4

  AST_DONE_WORD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pkt_done |-> mem_wdata[31:12] == 20'h0 && mem_wdata[11:0] <= cur_cap); // R6

  AST_OVF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> !run_en && st_ovf); // R7

  AST_BERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> !run_en && st_berr); // R9

  AST_PKT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pkt_done |=> st_pkt); // R10
endmodule

bind rxdma_top rxd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .rx_ready(rx_ready),
  .run_en(run_en), .st_pkt(st_pkt), .st_ovf(st_ovf), .st_berr(st_berr),
  .ev_pkt_done(ev_pkt_done), .ev_overflow(ev_overflow), .ev_bus_err(ev_bus_err),
  .cur_cap(cur_cap)
);

// File: tb/sim_rxdma_top.sv
`timescale 1ns/1ps
module sim_rxdma_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [256];
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  int          wr_count = 0;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  rxdma_top u0 (.*);

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_addr == err_addr) mem_err <= 1'b1;
      else if (mem_we) begin
        wr_count <= wr_count + 1;
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_desc(input int w, input logic [31:0] bufa, input logic [31:0] ctrl,
                          input logic [31:0] nxt);
    mem[w] = bufa; mem[w+1] = ctrl; mem[w+2] = nxt;
  endtask

  task automatic prefill(input int w, input int n);
    for (int i = 0; i < n; i++) mem[w+i] = 32'hEEEE_EEEE;
  endtask

  task automatic send_frame(input int len, input logic [7:0] base, input int err_idx);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_data = base + 8'(i);
      rx_last = (i == len - 1); rx_err = (i == err_idx);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
    reg_read(2'd0, v); chk("R1/R12 ctrl", v, 32'h0);
    reg_read(2'd1, v); chk("R1/R12 ptr", v, 32'h0);
    reg_read(2'd2, v); chk("R1/R12 status", v, 32'h0);
  endtask

  task automatic t_disabled;
    int w0;
    bit seen;
    w0 = wr_count; seen = 0;
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h55; rx_last = 1'b1;
    repeat (6) begin @(negedge clk); if (rx_ready) seen = 1; end
    rx_valid = 1'b0; rx_last = 1'b0;
    chk("R2 no accept while stopped", {31'b0, seen}, 32'h0);
    chk("R2 no write while stopped", 32'(wr_count - w0), 32'h0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    reg_write(2'd1, 32'h0); reg_write(2'd0, 32'h1);
    reg_read(2'd1, v); chk("R12 ptr readback", v, 32'h0);
    send_frame(10, 8'h10, -1);
    chk("R4 word0", mem[64], 32'h1011_1213);
    chk("R4 word1", mem[65], 32'h1415_1617);
    chk("R4 partial word", mem[66], 32'h1819_EEEE);
    chk("R5 writeback", mem[1], 32'h0000_000A);
    reg_read(2'd1, v); chk("R3 pointer advance", v, 32'h0000_000C);
    reg_read(2'd2, v); chk("R10 pkt flag", v, 32'h1);
  endtask

  task automatic t_second_and_ack;
    logic [31:0] v;
    send_frame(4, 8'h40, -1);
    chk("R4 full word", mem[80], 32'h4041_4243);
    chk("R5 writeback 4", mem[4], 32'h0000_0004);
    reg_write(2'd2, 32'h1);
    reg_read(2'd2, v); chk("R10 pending after one ack", v, 32'h1);
    reg_write(2'd2, 32'h1);
    reg_read(2'd2, v); chk("R10 clear after two acks", v, 32'h0);
  endtask

  task automatic t_truncate;
    logic [31:0] v;
    send_frame(9, 8'h60, -1);
    chk("R6 word0", mem[96], 32'h6061_6263);
    chk("R6 cut word", mem[97], 32'h6465_EEEE);
    chk("R6 beyond capacity", mem[98], 32'hEEEE_EEEE);
    chk("R6 length = capacity", mem[7], 32'h0000_0006);
    reg_read(2'd1, v); chk("R3 ring wrap", v, 32'h0);
    reg_write(2'd2, 32'h1);
  endtask

  task automatic t_errframe;
    logic [31:0] v;
    mem[1] = 32'h8000_0010;
    send_frame(6, 8'h70, 2);
    chk("R8 no writeback", mem[1], 32'h8000_0010);
    reg_read(2'd1, v); chk("R8 pointer kept", v, 32'h0);
    reg_read(2'd2, v); chk("R8 no status", v, 32'h0);
  endtask

  task automatic t_owned;
    logic [31:0] v;
    int w0;
    mem[1] = 32'h0000_0010;
    w0 = wr_count;
    send_frame(5, 8'h80, -1);
    reg_read(2'd2, v); chk("R7 overflow", v, 32'h4);
    reg_read(2'd0, v); chk("R7 run cleared", v, 32'h0);
    reg_read(2'd1, v); chk("R7 pointer kept", v, 32'h0);
    chk("R7 no write", 32'(wr_count - w0), 32'h0);
    reg_write(2'd2, 32'h4);
    reg_read(2'd2, v); chk("R10 overflow clear", v, 32'h0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    mem[1] = 32'h8000_0010; mem[4] = 32'h8000_0010;
    prefill(80, 4);
    reg_write(2'd1, 32'h0000_000C); reg_write(2'd0, 32'h1);
    send_frame(3, 8'h90, -1);
    chk("R11 data to new descriptor", mem[80], 32'h9091_92EE);
    chk("R11 writeback", mem[4], 32'h0000_0003);
    reg_read(2'd1, v); chk("R11 pointer", v, 32'h0000_0018);
    reg_write(2'd2, 32'h1);
  endtask

  task automatic t_buserr;
    logic [31:0] v;
    mem[7] = 32'h8000_0010;
    err_addr = 32'h0000_0180;
    send_frame(8, 8'hA0, -1);
    reg_read(2'd2, v); chk("R9 bus error flag", v, 32'h8);
    reg_read(2'd0, v); chk("R9 run cleared", v, 32'h0);
    chk("R9 no writeback", mem[7], 32'h8000_0010);
    reg_read(2'd1, v); chk("R9 pointer kept", v, 32'h0000_0018);
    chk("R9 frame drained", {31'b0, rx_ready}, 32'h0);
    reg_write(2'd2, 32'h8);
    reg_read(2'd2, v); chk("R10 bus error clear", v, 32'h0);
    err_addr = 32'hFFFF_FFF0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    set_desc(0, 32'h100, 32'h8000_0010, 32'h0C);
    set_desc(3, 32'h140, 32'h8000_0010, 32'h18);
    set_desc(6, 32'h180, 32'h8000_0006, 32'h00);
    prefill(64, 4); prefill(80, 4); prefill(96, 4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_basic();
    t_second_and_ack();
    t_truncate();
    t_errframe();
    t_owned();
    t_restart();
    t_buserr();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule